// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Single-Bit Operation Unit

This block carries out the prefixed bit-manipulation instruction group of an 8-bit processor datapath on one byte operand. Each clock it takes the operand, the current flag nibble, a 2-bit group code, a 3-bit selector and the 3-bit operand source code, and one clock later presents the new operand value, the new flags and the number of machine cycles the instruction costs. Which register supplies the operand and the memory access itself are handled elsewhere; the source code only sets the cost.

The group code chooses between the rotate/shift family, a single-bit test, a single-bit clear and a single-bit set. In the rotate/shift family the selector names one of eight operations, one of which exchanges the two nibbles; in the other three groups the selector is the bit index. The flag nibble is packed as bit 3 = zero (Z), bit 2 = subtract (N), bit 1 = half-carry (H), bit 0 = carry (C).

Top module: `sbu_core`

## Requirements
- R1: While rst_n is low, result_o, flags_o and mcycles_o are all zero; otherwise every output reflects the inputs sampled at the previous rising clock edge.
- R2: group_i encodes 0 = rotate/shift, 1 = bit test, 2 = bit clear, 3 = bit set; for groups 1 to 3, sel_i is the bit index (0 = least significant bit).
- R3: In group 0, sel_i = 0 rotates left circularly and sel_i = 1 rotates right circularly; carry receives the bit that leaves (bit 7 for left, bit 0 for right).
- R4: In group 0, sel_i = 2 rotates left through carry (old carry enters bit 0, bit 7 becomes carry) and sel_i = 3 rotates right through carry (old carry enters bit 7, bit 0 becomes carry).
- R5: In group 0, sel_i = 4 shifts left filling bit 0 with zero (carry = old bit 7); sel_i = 5 shifts right keeping bit 7 (carry = old bit 0); sel_i = 7 shifts right clearing bit 7 (carry = old bit 0).
- R6: In group 0, sel_i = 6 exchanges the upper and lower nibbles and clears carry.
- R7: Every group 0 operation clears N and H and sets Z exactly when the 8-bit result is zero.
- R8: Bit test sets Z when the selected bit is 0 and clears it otherwise, sets H, clears N, keeps C and returns the operand unchanged.
- R9: Bit clear and bit set change only the selected bit (to 0 and 1 respectively) and return the flags unchanged.
- R10: mcycles_o is 4 when src_i equals 6 (memory operand) and 2 for any other src_i, in every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| group_i | input | 2 | Operation group code |
| sel_i | input | 3 | Shift kind or bit index |
| src_i | input | 3 | Operand source code, 6 = memory |
| result_o | output | 8 | New operand value |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| mcycles_o | output | 3 | Machine cycle cost |

## Verification
Two things routinely land in one operation: a rotate through carry consumes the incoming carry and produces the outgoing carry in the same step, and the memory cost rule applies at the same time as any flag update. The stimulus sweeps every group, selector and operand value with the carry input both clear and set, while the source code walks through all eight values so that memory-cost cycles meet every operation. Each cycle the result, flags and cost are judged against a behavioural model evaluated on the inputs applied one cycle earlier.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 4;
    localparam int CYC_W   = 3;
    localparam int SEL_W   = 3;
    localparam int GRP_W   = 2;
    localparam int IDX_W   = $clog2(DATA_W);

    // flag bit positions inside the flag nibble
    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;

    // cost rule
    localparam int MEM_SRC = 6;
    localparam int REG_CYC = 2;
    localparam int MEM_CYC = 4;

    typedef enum logic [GRP_W-1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SET   = 2'd3
    } grp_e;

    typedef enum logic [SEL_W-1:0] {
        SH_ROL_C  = 3'd0,
        SH_ROR_C  = 3'd1,
        SH_ROL_T  = 3'd2,
        SH_ROR_T  = 3'd3,
        SH_SHL_A  = 3'd4,
        SH_SHR_A  = 3'd5,
        SH_NSWAP  = 3'd6,
        SH_SHR_L  = 3'd7
    } shop_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLAG_W-1:0] flags;
        logic [CYC_W-1:0]  cyc;
    } out_s;

endpackage

// File: rtl/sbu_shift.sv
module sbu_shift
    import sbu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  shop_e          op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           cout
);
    localparam int HALF = W / 2;

    always_comb begin
        y    = a;
        cout = 1'b0;
        case (op)
            SH_ROL_C: begin
                y    = {a[W-2:0], a[W-1]};
                cout = a[W-1];
            end
            SH_ROR_C: begin
                y    = {a[0], a[W-1:1]};
                cout = a[0];
            end
            SH_ROL_T: begin
                y    = {a[W-2:0], cin};
                cout = a[W-1];
            end
            SH_ROR_T: begin
                y    = {cin, a[W-1:1]};
                cout = a[0];
            end
            SH_SHL_A: begin
                y    = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            SH_SHR_A: begin
                y    = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            SH_NSWAP: begin
                y    = {a[HALF-1:0], a[W-1:HALF]};
                cout = 1'b0;
            end
            SH_SHR_L: begin
                y    = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            default: begin
                y    = a;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sbu_bitop.sv
module sbu_bitop
    import sbu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  grp_e           kind,
    input  logic [IW-1:0]  idx,
    input  logic [W-1:0]   a,
    output logic [W-1:0]   y,
    output logic           picked
);
    logic [W-1:0] hot;

    // one decoder slice per bit position
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign hot[i] = (idx == IW'(i));
    end

    always_comb begin
        case (kind)
            GRP_CLR: y = a & ~hot;
            GRP_SET: y = a | hot;
            default: y = a;
        endcase
        picked = |(a & hot);
    end

endmodule

// File: rtl/sbu_cost.sv
module sbu_cost
    import sbu_pkg::*;
#(
    parameter int SW      = SEL_W,
    parameter int CW      = CYC_W,
    parameter int MEM_SEL = MEM_SRC,
    parameter int R_CYC   = REG_CYC,
    parameter int M_CYC   = MEM_CYC
) (
    input  logic [SW-1:0] src,
    output logic [CW-1:0] cyc
);
    always_comb begin
        if (src == SW'(MEM_SEL)) cyc = CW'(M_CYC);
        else                     cyc = CW'(R_CYC);
    end

endmodule

// File: rtl/sbu_core.sv
module sbu_core
    import sbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        operand_i,
    input  logic [3:0]        flags_i,
    input  logic [1:0]        group_i,
    input  logic [2:0]        sel_i,
    input  logic [2:0]        src_i,
    output logic [7:0]        result_o,
    output logic [3:0]        flags_o,
    output logic [2:0]        mcycles_o
);
    grp_e              grp;
    logic [DATA_W-1:0] sh_y;
    logic              sh_c;
    logic [DATA_W-1:0] bo_y;
    logic              bo_bit;
    logic [CYC_W-1:0]  cost;
    out_s              out_d, out_q;

    assign grp = grp_e'(group_i);

    sbu_shift #(.W(DATA_W)) u_shift (
        .op   (shop_e'(sel_i)),
        .a    (operand_i),
        .cin  (flags_i[FC]),
        .y    (sh_y),
        .cout (sh_c)
    );

    sbu_bitop #(.W(DATA_W), .IW(IDX_W)) u_bitop (
        .kind   (grp),
        .idx    (sel_i[IDX_W-1:0]),
        .a      (operand_i),
        .y      (bo_y),
        .picked (bo_bit)
    );

    sbu_cost #(.SW(SEL_W), .CW(CYC_W)) u_cost (
        .src (src_i),
        .cyc (cost)
    );

    always_comb begin
        out_d       = '0;
        out_d.cyc   = cost;
        out_d.flags = flags_i;
        case (grp)
            GRP_SHIFT: begin
                out_d.data      = sh_y;
                out_d.flags[FZ] = (sh_y == '0);
                out_d.flags[FN] = 1'b0;
                out_d.flags[FH] = 1'b0;
                out_d.flags[FC] = sh_c;
            end
            GRP_TEST: begin
                out_d.data      = operand_i;
                out_d.flags[FZ] = ~bo_bit;
                out_d.flags[FN] = 1'b0;
                out_d.flags[FH] = 1'b1;
            end
            default: begin
                out_d.data = bo_y;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o  = out_q.data;
    assign flags_o   = out_q.flags;
    assign mcycles_o = out_q.cyc;

endmodule

// File: rtl/sbu_core_chk.sv
module sbu_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] operand_i,
    input logic [3:0] flags_i,
    input logic [1:0] group_i,
    input logic [2:0] sel_i,
    input logic [2:0] src_i,
    input logic [7:0] result_o,
    input logic [3:0] flags_o,
    input logic [2:0] mcycles_o
);
    logic live_q;

    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    // R10: cost follows the source code sampled one edge earlier
    p_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> mcycles_o == (($past(src_i) == 3'd6) ? 3'd4 : 3'd2));

    // R7: shift family clears N and H, Z tracks the result
    p_shift_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(group_i) == 2'd0) |->
            (flags_o[2:1] == 2'b00 && flags_o[3] == (result_o == 8'd0)));

    // R6: nibble exchange and carry cleared
    p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(group_i) == 2'd0 && $past(sel_i) == 3'd6) |->
            (result_o == {$past(operand_i[3:0]), $past(operand_i[7:4])} && !flags_o[0]));

    // R8: bit test keeps operand and carry, forces H, clears N
    p_test_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(group_i) == 2'd1) |->
            (result_o == $past(operand_i) && flags_o[0] == $past(flags_i[0])
             && flags_o[1] && !flags_o[2]));

    // R9: clear and set leave flags alone
    p_mod_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(group_i[1])) |-> flags_o == $past(flags_i));

    // R9: at most one bit differs after clear or set
    p_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(group_i[1])) |->
            $countones(result_o ^ $past(operand_i)) <= 1);

endmodule

bind sbu_core sbu_core_chk u_chk (.*);

// File: tb/sbu_core_test.sv
`timescale 1ns/1ps
module sbu_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] operand_i = '0;
    logic [3:0] flags_i = '0;
    logic [1:0] group_i = '0;
    logic [2:0] sel_i = '0;
    logic [2:0] src_i = '0;
    logic [7:0] result_o;
    logic [3:0] flags_o;
    logic [2:0] mcycles_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sbu_core uut (.*);

    // behavioural reference: integer arithmetic on the requirement text
    function automatic void model(input int g, input int s, input int a,
                                  input int f, input int src,
                                  output int r, output int rf, output int rc);
        int c, z, bitv;
        c  = f % 2;
        rc = (src == 6) ? 4 : 2;
        if (g == 0) begin
            int co;
            case (s)
                0: begin co = a / 128; r = (a * 2) % 256 + co; end
                1: begin co = a % 2;   r = a / 2 + co * 128; end
                2: begin co = a / 128; r = (a * 2) % 256 + c; end
                3: begin co = a % 2;   r = a / 2 + c * 128; end
                4: begin co = a / 128; r = (a * 2) % 256; end
                5: begin co = a % 2;   r = a / 2 + (a / 128) * 128; end
                6: begin co = 0;       r = (a % 16) * 16 + a / 16; end
                default: begin co = a % 2; r = a / 2; end
            endcase
            z  = (r == 0) ? 1 : 0;
            rf = z * 8 + co;
        end else if (g == 1) begin
            bitv = (a >> s) % 2;
            r    = a;
            rf   = (bitv == 0 ? 8 : 0) + 2 + c;
        end else begin
            bitv = (a >> s) % 2;
            if (g == 2) r = a - bitv * (1 << s);
            else        r = a + (1 - bitv) * (1 << s);
            rf = f;
        end
    endfunction

    function automatic string res_tag(input int g, input int s);
        if (g == 0) begin
            if (s < 2)       return "R3";
            else if (s < 4)  return "R4";
            else if (s == 6) return "R6";
            else             return "R5";
        end
        if (g == 1) return "R8 R2";
        return "R9 R2";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        int pg, ps, pa, pf, psrc;
        int er, ef, ec;
        bit have;
        have = 1'b0;
        pg = 0; ps = 0; pa = 0; pf = 0; psrc = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 result", int'(result_o), 0);
        check("R1 flags", int'(flags_o), 0);
        check("R1 cycles", int'(mcycles_o), 0);
        rst_n = 1'b1;
        for (int g = 0; g < 4; g++) begin
            for (int s = 0; s < 8; s++) begin
                for (int cv = 0; cv < 2; cv++) begin
                    for (int a = 0; a < 256; a++) begin
                        // drive: flags vary in the upper three bits, carry fixed per pass
                        operand_i = 8'(a);
                        flags_i   = 4'(((a % 8) << 1) | cv);
                        group_i   = 2'(g);
                        sel_i     = 3'(s);
                        src_i     = 3'((a + s) % 8);
                        @(negedge clk);
                        if (have) begin end
                        model(g, s, a, int'(flags_i), int'(src_i), er, ef, ec);
                        check(res_tag(g, s), int'(result_o), er);
                        if (g == 0)
                            check((s == 6) ? "R6 R7 flags" : "R7 flags", int'(flags_o), ef);
                        else if (g == 1)
                            check("R8 flags", int'(flags_o), ef);
                        else
                            check("R9 flags", int'(flags_o), ef);
                        check("R10 cycles", int'(mcycles_o), ec);
                        have = 1'b1;
                        pg = g; ps = s; pa = a; pf = int'(flags_i); psrc = int'(src_i);
                    end
                end
            end
        end
        // R1: reset again clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 result after reset", int'(result_o), 0);
        check("R1 cycles after reset", int'(mcycles_o), 0);
        if (pg + ps + pa + pf + psrc < 0) $display("unreachable");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule